// File: doc/BRIEF.md
# Binary-Field Montgomery Ladder Point Multiplier

This block computes the scalar product kP on a binary elliptic curve y^2 + xy = x^3 + ax^2 + b. It works only on the x coordinate and keeps two projective point pairs (X1, Z1) and (X2, Z2). It does not divide anywhere: the caller receives the four projective coordinates and does the conversion back to affine form and the recovery of y outside the block.

One request is made by pulsing `start` with the scalar, the base x coordinate and the curve constant b on the inputs. The block latches these values. It then walks the scalar from bit M-2 down to bit 0. For each bit it does one point addition and one point doubling, and all field products for both go through a single bit-serial GF(2^M) multiplier. The squarings and additions are combinational. When the last bit is done, `done` pulses for one cycle. The four coordinates stay on the outputs until the next accepted request.

Top module: `ladder_pmul`

## Requirements
- R1: While reset is active and after it is released, `done` is low and all four coordinate outputs read zero until a request completes.
- R2: Field elements are M-bit polynomial-basis vectors. Bit i holds the coefficient of z^i. Arithmetic is reduced by z^M + POLY_LOW, addition is bitwise XOR, and every multiply is done one at a time on one shared multiplier.
- R3: A `start` seen in the idle state captures `k_in`, `x_in` and `b_in`. Later changes on those inputs do not affect the request in progress.
- R4: The ladder begins with X1 = x, Z1 = 1, X2 = x^4 + b, Z2 = x^2. Bit M-1 of the scalar is taken as 1 whatever its value, so two scalars that differ only in that bit give identical outputs.
- R5: Scalar bits M-2 down to 0 are processed in that order. A 1 bit puts the sum into pair 1 and doubles pair 2. A 0 bit puts the sum into pair 2 and doubles pair 1.
- R6: The sum of the two pairs is Z = (X1·Z2 + X2·Z1)^2 and X = x·Z + (X1·Z2)·(X2·Z1), where x is the latched base coordinate.
- R7: Doubling pair (X, Z) gives X' = X^4 + b·Z^4 and Z' = X^2·Z^2.
- R8: The sum and the doubling of one bit both read the register values from before that bit. Both results are written back together, after both are complete.
- R9: `done` is high for exactly one cycle per request.
- R10: After `done`, the four outputs hold their values and `done` stays low until a new request is accepted.
- R11: A `start` that arrives while a request is running, or in the cycle when `done` is high, is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request pulse, accepted only while idle |
| k_in | input | M | Scalar; bit M-1 treated as 1 |
| x_in | input | M | Base point x coordinate |
| b_in | input | M | Curve constant b |
| x1_out | output | M | Projective X of pair 1 |
| z1_out | output | M | Projective Z of pair 1 |
| x2_out | output | M | Projective X of pair 2 |
| z2_out | output | M | Projective Z of pair 2 |
| done | output | 1 | One-cycle completion pulse |

## Verification
The two events that can meet in one cycle are a new `start` and the block's own activity. A start can arrive during the ladder loop, or in the single cycle when `done` is high and the controller is about to go back to idle. The bench raises `start` with fresh operands in the middle of a run and again exactly in the `done` cycle. It then judges the result two ways: the outputs must match the reference computed from the first latched operands, and after the `done` cycle no second `done` may appear and the coordinates must stay unchanged for a window of cycles.

// File: rtl/ladder_pkg.sv
package ladder_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_ADD,
    ST_DBL,
    ST_NEXT,
    ST_DONE
  } lad_state_e;
endpackage

// File: rtl/gf_sqr.sv
// Combinational squarer in GF(2^M): spread the bits, then fold back the high half.
module gf_sqr #(
  parameter int unsigned M = 163,
  parameter logic [M-1:0] POLY_LOW = 'hC9
) (
  input  logic [M-1:0] a,
  output logic [M-1:0] y
);
  localparam int unsigned W = 2 * M - 1;
  localparam logic [W-1:0] EXT = {{(M-1){1'b0}}, POLY_LOW};

  logic [W-1:0] w;

  always_comb begin
    w = '0;
    for (int i = 0; i < M; i++) w[2*i] = a[i];
    for (int i = W - 1; i >= M; i--) begin
      if (w[i]) begin
        w[i] = 1'b0;
        w = w ^ (EXT << (i - M));
      end
    end
    y = w[M-1:0];
  end
endmodule

// File: rtl/gf_sq_chain.sv
// DEPTH cascaded squarers; pw[j] = a^(2^(j+1)).
module gf_sq_chain #(
  parameter int unsigned M = 163,
  parameter logic [M-1:0] POLY_LOW = 'hC9,
  parameter int unsigned DEPTH = 2
) (
  input  logic [M-1:0]            a,
  output logic [DEPTH-1:0][M-1:0] pw
);
  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        gf_sqr #(.M(M), .POLY_LOW(POLY_LOW)) u_sq (.a(a), .y(pw[0]));
      end else begin : g_next
        gf_sqr #(.M(M), .POLY_LOW(POLY_LOW)) u_sq (.a(pw[g-1]), .y(pw[g]));
      end
    end
  endgenerate
endmodule

// File: rtl/gf_mul_serial.sv
// Bit-serial MSB-first GF(2^M) multiplier, M steps per product.
module gf_mul_serial #(
  parameter int unsigned M = 163,
  parameter logic [M-1:0] POLY_LOW = 'hC9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [M-1:0] op_a,
  input  logic [M-1:0] op_b,
  output logic [M-1:0] prod,
  output logic         busy,
  output logic         fin
);
  localparam int unsigned CW = $clog2(M + 1);

  logic [M-1:0]  acc_q, a_q, b_q;
  logic [CW-1:0] cnt_q;
  logic [M-1:0]  acc_shift, acc_d;

  always_comb begin
    acc_shift = {acc_q[M-2:0], 1'b0} ^ (acc_q[M-1] ? POLY_LOW : '0);
    acc_d     = acc_shift ^ (b_q[M-1] ? a_q : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        acc_q <= '0;
        a_q   <= op_a;
        b_q   <= op_b;
        cnt_q <= CW'(M);
        busy  <= 1'b1;
      end else if (busy) begin
        acc_q <= acc_d;
        b_q   <= {b_q[M-2:0], 1'b0};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  assign prod = acc_q;

  // R2: a single product is in flight at any time
  a_r2_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);
  a_r2_fin_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !busy);
endmodule

// File: rtl/ladder_ctrl.sv
// Sequencer: walks scalar bits, issues four add products then two double products.
module ladder_ctrl
  import ladder_pkg::*;
#(
  parameter int unsigned M  = 163,
  parameter int unsigned IW = $clog2(M)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mul_fin,
  output lad_state_e    state,
  output logic [1:0]    step,
  output logic [IW-1:0] idx,
  output logic          mul_go
);
  lad_state_e    state_d;
  logic [1:0]    step_d;
  logic [IW-1:0] idx_d;
  logic          pend_q, pend_d;

  always_comb begin
    state_d = state;
    step_d  = step;
    idx_d   = idx;
    mul_go  = 1'b0;
    pend_d  = pend_q;
    unique case (state)
      ST_IDLE: if (start) state_d = ST_INIT;
      ST_INIT: begin
        state_d = ST_ADD;
        step_d  = 2'd0;
        idx_d   = IW'(M - 2);
      end
      ST_ADD, ST_DBL: begin
        if (!pend_q) begin
          mul_go = 1'b1;
          pend_d = 1'b1;
        end
        if (mul_fin) begin
          pend_d = 1'b0;
          if (state == ST_ADD && step == 2'd3) begin
            state_d = ST_DBL;
            step_d  = 2'd0;
          end else if (state == ST_DBL && step == 2'd1) begin
            state_d = ST_NEXT;
            step_d  = 2'd0;
          end else begin
            step_d = step + 2'd1;
          end
        end
      end
      ST_NEXT: begin
        if (idx == '0) state_d = ST_DONE;
        else begin
          idx_d   = idx - 1'b1;
          state_d = ST_ADD;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      step   <= '0;
      idx    <= '0;
      pend_q <= 1'b0;
    end else begin
      state  <= state_d;
      step   <= step_d;
      idx    <= idx_d;
      pend_q <= pend_d;
    end
  end

  // R9: completion state lasts one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |=> (state == ST_IDLE));
  // R11: no request is accepted outside idle
  a_r11_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> (state != ST_INIT));
  // R5: bit index never starts above M-2
  a_r5_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADD) |-> (idx <= IW'(M - 2)));
endmodule

// File: rtl/ladder_pmul.sv
module ladder_pmul
  import ladder_pkg::*;
#(
  parameter int unsigned M = 163,
  parameter logic [M-1:0] POLY_LOW = 'hC9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] k_in,
  input  logic [M-1:0] x_in,
  input  logic [M-1:0] b_in,
  output logic [M-1:0] x1_out,
  output logic [M-1:0] z1_out,
  output logic [M-1:0] x2_out,
  output logic [M-1:0] z2_out,
  output logic         done
);
  localparam int unsigned IW = $clog2(M);
  localparam logic [M-1:0] ONE = M'(1);

  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  lad_state_e    state;
  logic [1:0]    step;
  logic [IW-1:0] idx;
  logic          mul_go, mul_busy, mul_fin;
  logic [M-1:0]  mul_a, mul_b, prod;

  ladder_ctrl #(.M(M), .IW(IW)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .mul_fin(mul_fin),
    .state(state), .step(step), .idx(idx), .mul_go(mul_go)
  );

  gf_mul_serial #(.M(M), .POLY_LOW(POLY_LOW)) u_mul (
    .clk(clk), .rst_n(rst_sync_n), .go(mul_go), .op_a(mul_a), .op_b(mul_b),
    .prod(prod), .busy(mul_busy), .fin(mul_fin)
  );

  logic [M-1:0] k_q, x_q, b_q;
  logic [M-1:0] x1_q, z1_q, x2_q, z2_q;
  logic [M-1:0] ta_q, tb_q, tc_q;
  logic [M-1:0] addx_q, addz_q, dblx_q, dblz_q;

  logic         bit_v;
  logic [M-1:0] xd, zd, chain_in;
  logic [1:0][M-1:0] xpw, zpw;
  logic [0:0][M-1:0] spw;

  assign bit_v    = k_q[idx];
  assign xd       = bit_v ? x2_q : x1_q;
  assign zd       = bit_v ? z2_q : z1_q;
  assign chain_in = (state == ST_INIT) ? x_q : xd;

  gf_sq_chain #(.M(M), .POLY_LOW(POLY_LOW), .DEPTH(2)) u_xsq (.a(chain_in), .pw(xpw));
  gf_sq_chain #(.M(M), .POLY_LOW(POLY_LOW), .DEPTH(2)) u_zsq (.a(zd), .pw(zpw));
  gf_sq_chain #(.M(M), .POLY_LOW(POLY_LOW), .DEPTH(1)) u_ssq (.a(ta_q ^ tb_q), .pw(spw));

  always_comb begin
    mul_a = x1_q;
    mul_b = z2_q;
    if (state == ST_ADD) begin
      unique case (step)
        2'd0: begin mul_a = x1_q;  mul_b = z2_q;   end
        2'd1: begin mul_a = x2_q;  mul_b = z1_q;   end
        2'd2: begin mul_a = x_q;   mul_b = spw[0]; end
        default: begin mul_a = ta_q; mul_b = tb_q; end
      endcase
    end else if (state == ST_DBL) begin
      if (step == 2'd0) begin mul_a = b_q;    mul_b = zpw[1]; end
      else              begin mul_a = xpw[0]; mul_b = zpw[0]; end
    end
  end

  logic cap_en, init_en, wb_en;
  assign cap_en  = (state == ST_IDLE) && start;
  assign init_en = (state == ST_INIT);
  assign wb_en   = (state == ST_NEXT);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      k_q <= '0;
      x_q <= '0;
      b_q <= '0;
    end else if (cap_en) begin
      k_q <= k_in;
      x_q <= x_in;
      b_q <= b_in;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ta_q <= '0; tb_q <= '0; tc_q <= '0;
      addx_q <= '0; addz_q <= '0; dblx_q <= '0; dblz_q <= '0;
    end else if (mul_fin) begin
      if (state == ST_ADD) begin
        unique case (step)
          2'd0: ta_q <= prod;
          2'd1: tb_q <= prod;
          2'd2: begin tc_q <= prod; addz_q <= spw[0]; end
          default: addx_q <= tc_q ^ prod;
        endcase
      end else if (state == ST_DBL) begin
        if (step == 2'd0) dblx_q <= xpw[1] ^ prod;
        else              dblz_q <= prod;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      x1_q <= '0; z1_q <= '0; x2_q <= '0; z2_q <= '0;
    end else if (init_en) begin
      x1_q <= x_q;
      z1_q <= ONE;
      x2_q <= xpw[1] ^ b_q;
      z2_q <= xpw[0];
    end else if (wb_en) begin
      if (bit_v) begin
        x1_q <= addx_q; z1_q <= addz_q;
        x2_q <= dblx_q; z2_q <= dblz_q;
      end else begin
        x2_q <= addx_q; z2_q <= addz_q;
        x1_q <= dblx_q; z1_q <= dblz_q;
      end
    end
  end

  assign x1_out = x1_q;
  assign z1_out = z1_q;
  assign x2_out = x2_q;
  assign z2_out = z2_q;
  assign done   = (state == ST_DONE);

  // R4: pair 1 Z starts at the field one
  a_r4_init_z1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_INIT) |=> (z1_q == ONE));
  // R8: coordinates move only at init or at write-back
  a_r8_wb_only: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_ADD || state == ST_DBL) |=> ($stable(x1_q) && $stable(z2_q)));
  // R10: outputs hold while idle
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_IDLE) |=> ($stable(x1_q) && $stable(z1_q) && $stable(x2_q) && $stable(z2_q)));
  // R2: the multiplier is never restarted while busy
  a_r2_go_free: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mul_go |-> !mul_busy);
endmodule

// File: tb/ladder_pmul_test.sv
`timescale 1ns/1ps
module ladder_pmul_test;
  localparam int unsigned M = 17;
  localparam logic [M-1:0] PL = 17'h9;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [M-1:0] k_in = '0, x_in = '0, b_in = '0;
  logic [M-1:0] x1_out, z1_out, x2_out, z2_out;
  logic done;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  ladder_pmul #(.M(M), .POLY_LOW(PL)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .k_in(k_in), .x_in(x_in), .b_in(b_in),
    .x1_out(x1_out), .z1_out(z1_out), .x2_out(x2_out), .z2_out(z2_out), .done(done)
  );

  function automatic logic [M-1:0] gmul(logic [M-1:0] a, logic [M-1:0] b);
    logic [M-1:0] acc = '0;
    for (int i = M - 1; i >= 0; i--) begin
      acc = {acc[M-2:0], 1'b0} ^ (acc[M-1] ? PL : '0);
      if (b[i]) acc = acc ^ a;
    end
    return acc;
  endfunction

  function automatic logic [M-1:0] gsq(logic [M-1:0] a);
    return gmul(a, a);
  endfunction

  // Reference ladder from R4..R8, returns {X1,Z1,X2,Z2}
  function automatic logic [4*M-1:0] ref_ladder(logic [M-1:0] k, logic [M-1:0] x, logic [M-1:0] b);
    logic [M-1:0] x1, z1, x2, z2, ax, az, dx, dz, p, q, xs, zs;
    x1 = x; z1 = 1; x2 = gsq(gsq(x)) ^ b; z2 = gsq(x);
    for (int i = M - 2; i >= 0; i--) begin
      p  = gmul(x1, z2);
      q  = gmul(x2, z1);
      az = gsq(p ^ q);
      ax = gmul(x, az) ^ gmul(p, q);
      xs = k[i] ? x2 : x1;
      zs = k[i] ? z2 : z1;
      dx = gsq(gsq(xs)) ^ gmul(b, gsq(gsq(zs)));
      dz = gmul(gsq(xs), gsq(zs));
      if (k[i]) begin x1 = ax; z1 = az; x2 = dx; z2 = dz; end
      else      begin x2 = ax; z2 = az; x1 = dx; z1 = dz; end
    end
    return {x1, z1, x2, z2};
  endfunction

  task automatic chk(string tag, logic [M-1:0] act, logic [M-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // mode 0 plain, 1 start+new inputs mid-run, 2 start during done cycle
  task automatic run_case(logic [M-1:0] k, logic [M-1:0] x, logic [M-1:0] b, int mode, string tag);
    logic [4*M-1:0] e;
    int n;
    logic [M-1:0] h1, h2, h3, h4;
    e = ref_ladder(k, x, b);
    @(negedge clk);
    k_in = k; x_in = x; b_in = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mode == 1) begin
      repeat (30) @(negedge clk);
      k_in = $urandom; x_in = $urandom; b_in = $urandom; start = 1'b1;  // R3 R11
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < LIMIT) begin @(negedge clk); n++; end
    checks++;
    if (!done) begin
      failures++;
      $display("FAIL R9 %s done actual=0 expected=1", tag);
      return;
    end
    chk({"R5/R6 X1 ", tag}, x1_out, e[4*M-1:3*M]);
    chk({"R5/R6 Z1 ", tag}, z1_out, e[3*M-1:2*M]);
    chk({"R7/R8 X2 ", tag}, x2_out, e[2*M-1:M]);
    chk({"R7/R8 Z2 ", tag}, z2_out, e[M-1:0]);
    h1 = x1_out; h2 = z1_out; h3 = x2_out; h4 = z2_out;
    if (mode == 2) begin
      x_in = ~x; start = 1'b1;  // R11: start in the done cycle
    end
    @(negedge clk);
    start = 1'b0;
    chk({"R9 done width ", tag}, M'(done), M'(0));
    if (mode == 2) begin
      n = 0;
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        if (done) n++;
        if (x1_out !== h1 || z1_out !== h2 || x2_out !== h3 || z2_out !== h4) n += 100;
      end
      chk("R10/R11 hold after done", M'(n), M'(0));
    end
  endtask

  initial begin
    #(2000000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [4*M-1:0] ea, eb;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 done in reset", M'(done), M'(0));
    chk("R1 x1 in reset", x1_out, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 z2 after reset", z2_out, '0);
    chk("R1 done after reset", M'(done), M'(0));

    // R2/R5 directed patterns
    run_case(17'h10000, 17'h00002, 17'h00001, 0, "only-msb");
    run_case(17'h1FFFF, 17'h1ABCD, 17'h0F0F1, 0, "all-ones");
    run_case(17'h15555, 17'h00001, 17'h00000, 0, "x1-b0 R2");
    run_case(17'h1AAAA, 17'h1FFFF, 17'h1FFFF, 0, "max-fields");
    // R4: bit M-1 ignored
    ea = ref_ladder(17'h1234F, 17'h0ACE1, 17'h03141);
    eb = ref_ladder(17'h0234F, 17'h0ACE1, 17'h03141);
    chk("R4 bench msb", M'(ea == eb), M'(1));
    run_case(17'h0234F, 17'h0ACE1, 17'h03141, 0, "R4 msb-clear");
    // R3/R11: start and new inputs during a run
    run_case(17'h1C3A5, 17'h05A5A, 17'h12345, 1, "R3 busy-start");
    // R10/R11: start in the done cycle
    run_case(17'h1F00F, 17'h0BEEF, 17'h00777, 2, "R11 done-start");
    for (int r = 0; r < 16; r++) begin
      logic [M-1:0] rk, rx, rb;
      rk = M'($urandom); rk[M-1] = 1'b1;
      rx = M'($urandom); rb = M'($urandom);
      run_case(rk, rx, rb, 0, "random");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule